// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two direction predictors side by side and a third table that picks between them. The local predictor is two-level: a table of per-branch outcome patterns, selected by low PC bits, whose pattern then selects a saturating counter. The global predictor is a table of 2-bit saturating counters addressed by a shift register of the most recent resolved outcomes. The choice table, addressed by that same shift register, holds 2-bit counters whose top bit says which component to believe.

Lookup is combinational. The front end presents a PC and reads back the final prediction, both component predictions, and the three indices that were used. It keeps those values with the branch. When the branch resolves, it returns them with the real outcome on the update port. All state changes on the rising clock edge of that update. Reset is synchronous and active high.

Top module: `tourney_predictor`

## Requirements
- R1: After reset, every lookup returns not-taken on the final and both component outputs, `lk_ghist` reads 0, and `lk_lpat` reads 0 for every PC.
- R2: The local history entry is selected by `lk_pc[9:0]`, which appears on `lk_lidx`. PC bits above bit 9 have no effect on the entry selected.
- R3: An update shifts `up_taken` into bit 0 of local history entry `up_lidx` and drops bit 9. `lk_lpat` shows the entry for the PC being looked up, in the same cycle.
- R4: Local counters are 3 bits wide and reset to 3 (binary 011). An update at index `up_lpat` adds one on taken, saturating at 7, and subtracts one on not-taken, saturating at 0. `lk_local_taken` is the counter MSB at index `lk_lpat`.
- R5: Global counters are 2 bits wide and reset to 1. An update at index `up_ghist` adds one on taken, saturating at 3, and subtracts one on not-taken, saturating at 0. `lk_global_taken` is the MSB of the counter at `lk_ghist`.
- R6: Each update shifts `up_taken` into bit 0 of the 12-bit global history and drops bit 11. With no update, the history holds its value.
- R7: The final prediction equals `lk_global_taken` when the choice counter at `lk_ghist` has MSB 1, and equals `lk_local_taken` when its MSB is 0. Choice counters reset to 1, which favours local.
- R8: A choice counter at `up_ghist` changes only when `up_local_taken` differs from `up_global_taken`. It adds one, saturating at 3, when the global prediction matched `up_taken`, and subtracts one, saturating at 0, otherwise.
- R9: With `up_valid` low, a constant PC gives constant lookup outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | 32 | PC of the branch being looked up |
| lk_taken | output | 1 | Final prediction |
| lk_local_taken | output | 1 | Local component prediction |
| lk_global_taken | output | 1 | Global component prediction |
| lk_lidx | output | 10 | Local history entry index used |
| lk_lpat | output | 10 | Local pattern read, index of the local counter |
| lk_ghist | output | 12 | Global history, index of the global and choice counters |
| up_valid | input | 1 | Apply an update this cycle |
| up_lidx | input | 10 | Saved local history index |
| up_lpat | input | 10 | Saved local pattern |
| up_ghist | input | 12 | Saved global history |
| up_local_taken | input | 1 | Saved local prediction |
| up_global_taken | input | 1 | Saved global prediction |
| up_taken | input | 1 | Resolved outcome |

## Verification
Local training runs long taken runs and long not-taken runs into one counter. These show whether the counter saturates or wraps, because the prediction flips back only after the expected number of opposite outcomes. Mixed outcome sequences into one history entry, followed by a lookup from an aliasing PC, separate a correct shift order and index selection from a reversed shift or a wrong index. Before each global or choice lookup, the global history is steered to a known value through twelve filler updates. Choice training then feeds one disagreeing update with global correct, one agreeing update, and one disagreeing update with local correct. The final selection after each step shows whether the counter moved, and in which direction, only when the components disagreed.

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
  parameter int PC_W    = 32,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int LCTR_W  = 3,
  parameter int GHIST_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PC_W-1:0]    lk_pc,
  output logic               lk_taken,
  output logic               lk_local_taken,
  output logic               lk_global_taken,
  output logic [LIDX_W-1:0]  lk_lidx,
  output logic [LHIST_W-1:0] lk_lpat,
  output logic [GHIST_W-1:0] lk_ghist,
  input  logic               up_valid,
  input  logic [LIDX_W-1:0]  up_lidx,
  input  logic [LHIST_W-1:0] up_lpat,
  input  logic [GHIST_W-1:0] up_ghist,
  input  logic               up_local_taken,
  input  logic               up_global_taken,
  input  logic               up_taken
);
  localparam int LH_N = 1 << LIDX_W;
  localparam int LC_N = 1 << LHIST_W;
  localparam int G_N  = 1 << GHIST_W;
  localparam logic [LCTR_W-1:0] LC_INIT = {1'b0, {(LCTR_W-1){1'b1}}};
  localparam logic [LCTR_W-1:0] LC_MAX  = '1;

  logic [LHIST_W-1:0] lhist  [LH_N];
  logic [LCTR_W-1:0]  lctr   [LC_N];
  logic [1:0]         gctr   [G_N];
  logic [1:0]         choice [G_N];
  logic [GHIST_W-1:0] ghr;

  function automatic logic [LCTR_W-1:0] lstep(input logic [LCTR_W-1:0] c, input logic inc);
    if (inc) return (c == LC_MAX) ? c : c + 1'b1;
    return (c == '0) ? c : c - 1'b1;
  endfunction

  function automatic logic [1:0] step2(input logic [1:0] c, input logic inc);
    if (inc) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  assign lk_lidx         = lk_pc[LIDX_W-1:0];
  assign lk_lpat         = lhist[lk_lidx];
  assign lk_local_taken  = lctr[lk_lpat][LCTR_W-1];
  assign lk_ghist        = ghr;
  assign lk_global_taken = gctr[ghr][1];
  assign lk_taken        = choice[ghr][1] ? lk_global_taken : lk_local_taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LH_N; i++) lhist[i] <= '0;
      for (int i = 0; i < LC_N; i++) lctr[i] <= LC_INIT;
      for (int i = 0; i < G_N; i++) begin
        gctr[i]   <= 2'b01;
        choice[i] <= 2'b01;
      end
      ghr <= '0;
    end else if (up_valid) begin
      lhist[up_lidx] <= {lhist[up_lidx][LHIST_W-2:0], up_taken};
      lctr[up_lpat]  <= lstep(lctr[up_lpat], up_taken);
      gctr[up_ghist] <= step2(gctr[up_ghist], up_taken);
      if (up_local_taken != up_global_taken)
        choice[up_ghist] <= step2(choice[up_ghist], up_global_taken == up_taken);
      ghr <= {ghr[GHIST_W-2:0], up_taken};
    end
  end
endmodule

module tourney_predictor_chk #(
  parameter int PC_W    = 32,
  parameter int LHIST_W = 10,
  parameter int GHIST_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic [PC_W-1:0]    lk_pc,
  input logic               lk_taken,
  input logic               lk_local_taken,
  input logic               lk_global_taken,
  input logic [LHIST_W-1:0] lk_lpat,
  input logic [GHIST_W-1:0] lk_ghist,
  input logic               up_valid,
  input logic               up_taken
);
  assert_ghist_cleared_R1: assert property (@(posedge clk) rst |=> lk_ghist == '0);

  assert_ghist_shift_R6: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> lk_ghist == {$past(lk_ghist[GHIST_W-2:0]), $past(up_taken)});

  assert_ghist_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(lk_ghist));

  assert_agree_passes_R7: assert property (@(posedge clk) disable iff (rst)
    (lk_local_taken == lk_global_taken) |-> lk_taken == lk_local_taken);

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!up_valid && !$past(rst)) ##1 $stable(lk_pc) |-> $stable(lk_taken) && $stable(lk_lpat));
endmodule

bind tourney_predictor tourney_predictor_chk #(.PC_W(PC_W), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)) u_chk (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
  .lk_local_taken(lk_local_taken), .lk_global_taken(lk_global_taken),
  .lk_lpat(lk_lpat), .lk_ghist(lk_ghist), .up_valid(up_valid), .up_taken(up_taken)
);

// File: tb/tourney_predictor_bench.sv
module tourney_predictor_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] lk_pc = '0;
  logic        lk_taken, lk_local_taken, lk_global_taken;
  logic [9:0]  lk_lidx, lk_lpat;
  logic [11:0] lk_ghist;
  logic        up_valid = 0;
  logic [9:0]  up_lidx = '0, up_lpat = '0;
  logic [11:0] up_ghist = '0;
  logic        up_local_taken = 0, up_global_taken = 0, up_taken = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tourney_predictor u_tourney_predictor (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    up_valid = 0;
    @(negedge clk);
    @(negedge clk) rst = 0;
  endtask

  task automatic upd(input logic [9:0] li, input logic [9:0] lp, input logic [11:0] gh,
                     input logic lt, input logic gt, input logic t);
    @(negedge clk);
    up_lidx = li; up_lpat = lp; up_ghist = gh;
    up_local_taken = lt; up_global_taken = gt; up_taken = t; up_valid = 1;
    @(negedge clk) up_valid = 0;
  endtask

  task automatic look(input logic [31:0] pc);
    lk_pc = pc;
    #1;
  endtask

  task automatic set_ghr(input logic [11:0] v);
    for (int i = 11; i >= 0; i--) upd(10'd1023, 10'd1023, 12'hFFF, 1'b0, 1'b0, v[i]);
    look(lk_pc);
    check("R6 ghist steered", lk_ghist, v);
  endtask

  task automatic t_reset();
    do_reset();
    look(32'h0000_1234);
    check("R1 final", lk_taken, 0);
    check("R1 local", lk_local_taken, 0);
    check("R1 global", lk_global_taken, 0);
    check("R1 ghist", lk_ghist, 0);
    check("R1 lpat", lk_lpat, 0);
  endtask

  task automatic t_lhist();
    do_reset();
    upd(10'd3, 10'd500, 12'hFFF, 0, 0, 1);
    upd(10'd3, 10'd500, 12'hFFF, 0, 0, 0);
    upd(10'd3, 10'd500, 12'hFFF, 0, 0, 1);
    look(32'h0000_0403);
    check("R2 lidx low bits", lk_lidx, 3);
    check("R3 pattern 101", lk_lpat, 5);
    look(32'h0000_0004);
    check("R3 other entry untouched", lk_lpat, 0);
    for (int i = 0; i < 11; i++) upd(10'd3, 10'd500, 12'hFFF, 0, 0, 1);
    look(32'hFFFF_FC03);
    check("R3 oldest dropped", lk_lpat, 1023);
  endtask

  task automatic t_lctr();
    do_reset();
    upd(10'd100, 10'd0, 12'hFFF, 0, 0, 1);
    look(32'h0);
    check("R4 011->100 taken", lk_local_taken, 1);
    for (int i = 0; i < 6; i++) upd(10'd100, 10'd0, 12'hFFF, 0, 0, 1);
    for (int i = 0; i < 3; i++) upd(10'd100, 10'd0, 12'hFFF, 0, 0, 0);
    look(32'h0);
    check("R4 upper saturation", lk_local_taken, 1);
    upd(10'd100, 10'd0, 12'hFFF, 0, 0, 0);
    look(32'h0);
    check("R4 drops below half", lk_local_taken, 0);
    for (int i = 0; i < 6; i++) upd(10'd100, 10'd0, 12'hFFF, 0, 0, 0);
    for (int i = 0; i < 3; i++) upd(10'd100, 10'd0, 12'hFFF, 0, 0, 1);
    look(32'h0);
    check("R4 lower saturation", lk_local_taken, 0);
    upd(10'd100, 10'd0, 12'hFFF, 0, 0, 1);
    look(32'h0);
    check("R4 recovers after four", lk_local_taken, 1);
  endtask

  task automatic t_gctr();
    do_reset();
    upd(10'd1023, 10'd1023, 12'd5, 0, 0, 1);
    set_ghr(12'd5);
    check("R5 01->10 taken", lk_global_taken, 1);
    upd(10'd1023, 10'd1023, 12'd5, 0, 0, 1);
    upd(10'd1023, 10'd1023, 12'd5, 0, 0, 1);
    upd(10'd1023, 10'd1023, 12'd5, 0, 0, 0);
    set_ghr(12'd5);
    check("R5 saturated then one down", lk_global_taken, 1);
    upd(10'd1023, 10'd1023, 12'd5, 0, 0, 0);
    set_ghr(12'd5);
    check("R5 second down", lk_global_taken, 0);
    check("R7 local chosen at reset choice", lk_taken, lk_local_taken);
  endtask

  task automatic t_choice();
    do_reset();
    for (int i = 0; i < 3; i++) upd(10'd1023, 10'd1023, 12'd9, 1, 1, 1);
    set_ghr(12'd9);
    look(32'h0);
    check("R7 global ready", lk_global_taken, 1);
    check("R7 weak choice selects local", lk_taken, 0);
    upd(10'd1023, 10'd1023, 12'd9, 0, 1, 1);
    set_ghr(12'd9);
    look(32'h0);
    check("R8 moved to global", lk_taken, 1);
    upd(10'd1023, 10'd1023, 12'd9, 1, 1, 1);
    upd(10'd1023, 10'd1023, 12'd9, 0, 1, 0);
    set_ghr(12'd9);
    look(32'h0);
    check("R8 agree no move then back to local", lk_taken, 0);
    check("R8 global still taken", lk_global_taken, 1);
  endtask

  task automatic t_idle();
    look(32'h0);
    repeat (3) @(negedge clk);
    look(32'h0);
    check("R9 idle stable", lk_taken, 0);
  endtask

  initial begin
    t_reset();
    t_lhist();
    t_lctr();
    t_gctr();
    t_choice();
    t_idle();
    t_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule